// File: doc/BRIEF.md
# Single-Level DVMA Page Translator

This block turns a device virtual address from an I/O master into a 36-bit physical address. It uses a single flat page table held in main memory, with one 4-byte entry for every 4 KB page. For each request it computes where that page's entry sits, makes one 32-bit read on its memory port, and checks the returned entry. It then finishes with either a physical address and a permission, or a fault.

The table base and the size of the translation window come in as inputs. The block samples them when it accepts a request. The window is 16 MB shifted left by a 3-bit size code, so it runs from 16 MB up to 2 GB. The address bits above the window are dropped before the table is indexed.

On a fault the block loads a fault status word and a page-aligned fault address, and it raises an interrupt. The interrupt stays high until the acknowledge input is pulsed. The block serves one translation at a time.

Top module: `dvma_xlate`

## Requirements
- R1: A successful translation returns `pa_o = {entry[31:8], addr[11:0]}`. The page offset passes through unchanged and the upper 24 entry bits form the physical page number.
- R2: The entry read address is `(base << 4) + (((addr & (2^(24+win) - 1)) >> 10) & ~3)`, taken modulo 2^36. Here win is `win_sel_i`, sampled when the request is accepted.
- R3: An entry with its valid bit (bit 1) clear makes the request fault, whether it is a read or a write.
- R4: A write whose entry has the writable bit (bit 2) clear faults. A read of such an entry succeeds with read-only permission.
- R5: On success `perm_wr_o` is 1 when the writable bit is set and 0 otherwise. The cacheable bit (bit 7) and bit 0 have no effect on the result.
- R6: On a fault `fsr_o` becomes 0xC0820000 for a write and 0xC0860000 for a read. For a read, bit 18 is also set.
- R7: On a fault `far_o` becomes `{addr[31:12], 12'h000}` and `irq_o` goes high in the same cycle as `done_o`. `irq_o` stays high until `irq_ack_i` is sampled high, which clears it the next cycle.
- R8: `req_ready_o` is high only when no translation is in flight. It goes low the cycle after acceptance, and `done_o` pulses for exactly one cycle, one cycle after `mem_rvalid_i`. `req_ready_o` returns high the cycle after `done_o`.
- R9: `mem_req_o` and `mem_addr_o` hold steady from the cycle after acceptance until `mem_rvalid_i`, whatever the latency, including zero wait cycles.
- R10: A successful translation leaves `fsr_o`, `far_o` and `irq_o` unchanged.
- R11: After reset `req_ready_o`=1, `mem_req_o`=0, `done_o`=0, `irq_o`=0, `fsr_o`=0x00800000 and `far_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translator idle, request accepted when valid |
| req_addr_i | input | 32 | Device virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| base_i | input | 32 | Page table base, in units of 16 bytes |
| win_sel_i | input | 3 | Window size code, size = 16 MB << code |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 36 | Entry byte address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 32 | Entry word, big-endian byte order already assembled |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 36 | Physical address, valid with done_o on success |
| fault_o | output | 1 | Translation faulted, valid with done_o |
| perm_wr_o | output | 1 | Read-write permission granted, valid with done_o |
| fsr_o | output | 32 | Fault status word |
| far_o | output | 32 | Fault address, page aligned |
| irq_o | output | 1 | Fault interrupt |
| irq_ack_i | input | 1 | Clears irq_o |

## Verification
Directed cases come first. They cover the smallest and largest window codes, with address bits above the window set, so a wrong mask shows up as a wrong entry address. A full page offset separates offset pass-through from page-number placement. The four combinations of valid bit, writable bit and access direction separate the two fault causes and the two permissions, and a read fault is kept apart from a write fault by status bit 18. Random requests then mix window codes, bases, entry bits and memory latencies of zero to three cycles. Between them they show whether the memory request holds steady, whether a success disturbs earlier fault state, and whether the interrupt persists until acknowledged.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int PG_SH = 12;

  typedef struct packed {
    logic [23:0] ppn;
    logic        cache;
    logic [3:0]  rsvd;
    logic        wr;
    logic        vld;
    logic        waz;
  } pte_t;

  localparam logic [31:0] FSR_FAULT = 32'hC082_0000;
  localparam logic [31:0] FSR_RST   = 32'h0080_0000;
  localparam int          FSR_RD_B  = 18;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RESP} xl_st_e;
endpackage

// File: rtl/dvma_walk_addr.sv
module dvma_walk_addr #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int WIN_MIN = 24,
  parameter int SEL_W   = 3
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [31:0]      base_i,
  input  logic [SEL_W-1:0] win_sel_i,
  output logic [PA_W-1:0]  ent_addr_o
);
  localparam int SH_W = 6;

  logic [SH_W-1:0] win_log2;
  logic [VA_W-1:0] win_mask;
  logic [VA_W-1:0] idx;

  assign win_log2   = SH_W'(WIN_MIN) + SH_W'(win_sel_i);
  assign win_mask   = ~({VA_W{1'b1}} << win_log2);
  // one 4-byte entry per page
  assign idx        = ((va_i & win_mask) >> (dvma_pkg::PG_SH - 2)) & ~VA_W'(3);
  assign ent_addr_o = (PA_W'(base_i) << 4) + PA_W'(idx);
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input  logic [31:0]     pte_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            write_i,
  output logic            fault_o,
  output logic            perm_wr_o,
  output logic [PA_W-1:0] pa_o
);
  import dvma_pkg::*;

  pte_t pte;
  logic unused_pte_bits;

  assign pte             = pte_t'(pte_i);
  assign unused_pte_bits = ^{pte.cache, pte.rsvd, pte.waz, va_i[VA_W-1:PG_SH]};
  assign fault_o         = !pte.vld || (write_i && !pte.wr);
  assign perm_wr_o       = pte.wr;
  assign pa_o            = PA_W'({pte.ppn, va_i[PG_SH-1:0]});
endmodule

// File: rtl/dvma_fault_regs.sv
module dvma_fault_regs #(
  parameter int VA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_i,
  input  logic                          rd_i,
  input  logic [VA_W-dvma_pkg::PG_SH-1:0] vpn_i,
  input  logic                          ack_i,
  output logic [31:0]                   fsr_o,
  output logic [VA_W-1:0]               far_o,
  output logic                          irq_o
);
  import dvma_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_o <= FSR_RST;
      far_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (set_i) begin
        fsr_o           <= FSR_FAULT;
        fsr_o[FSR_RD_B] <= rd_i;
        far_o           <= {vpn_i, {PG_SH{1'b0}}};
      end
      // a new fault wins over a simultaneous ack
      if (set_i)      irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int WIN_MIN = 24,
  parameter int SEL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_addr_i,
  input  logic             req_write_i,
  input  logic [31:0]      base_i,
  input  logic [SEL_W-1:0] win_sel_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o,
  output logic             perm_wr_o,
  output logic [31:0]      fsr_o,
  output logic [VA_W-1:0]  far_o,
  output logic             irq_o,
  input  logic             irq_ack_i
);
  import dvma_pkg::*;

  xl_st_e          st_q;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [PA_W-1:0] ent_q, ent_d;
  logic [PA_W-1:0] pa_q, pa_d;
  logic            fault_q, fault_d, perm_q, perm_d;
  logic            accept, resp;

  assign accept = (st_q == ST_IDLE) && req_valid_i;
  assign resp   = (st_q == ST_FETCH) && mem_rvalid_i;

  dvma_walk_addr #(.VA_W(VA_W), .PA_W(PA_W), .WIN_MIN(WIN_MIN), .SEL_W(SEL_W)) walk_i (
    .va_i(req_addr_i), .base_i(base_i), .win_sel_i(win_sel_i), .ent_addr_o(ent_d)
  );

  dvma_pte_check #(.VA_W(VA_W), .PA_W(PA_W)) chk_pte_i (
    .pte_i(mem_rdata_i), .va_i(va_q), .write_i(wr_q),
    .fault_o(fault_d), .perm_wr_o(perm_d), .pa_o(pa_d)
  );

  dvma_fault_regs #(.VA_W(VA_W)) flt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(resp && fault_d), .rd_i(!wr_q),
    .vpn_i(va_q[VA_W-1:PG_SH]), .ack_i(irq_ack_i),
    .fsr_o(fsr_o), .far_o(far_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      ent_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      perm_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_FETCH;
          va_q  <= req_addr_i;
          wr_q  <= req_write_i;
          ent_q <= ent_d;
        end
        ST_FETCH: if (resp) begin
          st_q    <= ST_RESP;
          pa_q    <= fault_d ? '0 : pa_d;
          fault_q <= fault_d;
          perm_q  <= !fault_d && perm_d;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_FETCH);
  assign mem_addr_o  = ent_q;
  assign done_o      = (st_q == ST_RESP);
  assign pa_o        = pa_q;
  assign fault_o     = fault_q;
  assign perm_wr_o   = perm_q;
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 36
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            done_o,
  input logic            fault_o,
  input logic [31:0]     fsr_o,
  input logic [VA_W-1:0] far_o,
  input logic            irq_o
);
  AST_DONE_TO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o && !done_o); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R8
  AST_DONE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o && !req_ready_o); // R8
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R9
  AST_FAULT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> irq_o); // R7
  AST_FAR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> far_o[11:0] == 12'h000); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> done_o && fault_o); // R7
  AST_FSR_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> (fsr_o & 32'hFFFB_FFFF) == 32'hC082_0000); // R6
  AST_SUCCESS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> $stable(fsr_o) && $stable(far_o)); // R10
endmodule

bind dvma_xlate dvma_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
  .done_o(done_o), .fault_o(fault_o), .fsr_o(fsr_o), .far_o(far_o), .irq_o(irq_o)
);

// File: tb/dvma_xlate_tb_top.sv
module dvma_xlate_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_ready_o, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0, base_i = '0;
  logic [2:0]  win_sel_i = '0;
  logic        mem_req_o, mem_rvalid_i = 1'b0;
  logic [35:0] mem_addr_o, pa_o;
  logic [31:0] mem_rdata_i = '0, fsr_o, far_o;
  logic        done_o, fault_o, perm_wr_o, irq_o, irq_ack_i = 1'b0;

  int checks = 0, fails = 0;
  logic [31:0] fsr_m = 32'h0080_0000, far_m = '0;
  logic        irq_m = 1'b0;

  always #10 clk_i = ~clk_i;

  dvma_xlate dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_ent(logic [31:0] b, logic [2:0] w, logic [31:0] a);
    logic [63:0] m = (64'd1 << (24 + w)) - 1;
    logic [63:0] o = ((64'(a) & m) >> 10) & ~64'd3;
    return 36'((64'(b) << 4) + o);
  endfunction

  function automatic logic [31:0] mk_pte(logic [23:0] ppn, logic c, logic w, logic v, logic z);
    return {ppn, c, 4'b0, w, v, z};
  endfunction

  task automatic xlate(logic [31:0] a, logic wr, logic [31:0] b, logic [2:0] w,
                       logic [31:0] pte, int lat);
    logic [35:0] ent = exp_ent(b, w, a);
    logic flt = !pte[1] || (wr && !pte[2]);
    @(negedge clk_i);
    chk("R8 ready idle", req_ready_o, 1);
    chk("R8 done low", done_o, 0);
    req_valid_i = 1; req_addr_i = a; req_write_i = wr; base_i = b; win_sel_i = w;
    @(negedge clk_i);
    req_valid_i = 0; base_i = ~b; win_sel_i = ~w;
    chk("R8 busy", req_ready_o, 0);
    chk("R9 mem_req", mem_req_o, 1);
    chk("R2 entry addr", mem_addr_o, ent);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk_i);
      chk("R9 hold req", mem_req_o, 1);
      chk("R9 hold addr", mem_addr_o, ent);
      chk("R8 no early done", done_o, 0);
    end
    mem_rvalid_i = 1; mem_rdata_i = pte;
    @(negedge clk_i);
    mem_rvalid_i = 0; mem_rdata_i = $urandom;
    chk("R8 done pulse", done_o, 1);
    chk("R8 mem idle", mem_req_o, 0);
    chk(pte[1] ? "R4 fault" : "R3 fault", fault_o, flt);
    if (flt) begin
      fsr_m = 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000);
      far_m = {a[31:12], 12'h000};
      irq_m = 1;
    end else begin
      chk("R1 pa", pa_o, {pte[31:8], a[11:0]});
      chk("R5 perm", perm_wr_o, pte[2]);
    end
    chk(flt ? "R6 fsr" : "R10 fsr", fsr_o, fsr_m);
    chk(flt ? "R7 far" : "R10 far", far_o, far_m);
    chk(flt ? "R7 irq" : "R10 irq", irq_o, irq_m);
  endtask

  task automatic ack_irq();
    @(negedge clk_i); irq_ack_i = 1;
    @(negedge clk_i); irq_ack_i = 0; irq_m = 0;
    chk("R7 irq cleared", irq_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (2) @(negedge clk_i);
    chk("R11 ready", req_ready_o, 1);
    chk("R11 mem_req", mem_req_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R11 fsr", fsr_o, 32'h0080_0000);
    chk("R11 far", far_o, 0);
    rst_ni = 1;
    // window masking, smallest and largest
    xlate(32'hFFFF_F123, 0, 32'h0012_3400, 3'd0, mk_pte(24'hABCDEF, 1, 0, 1, 1), 0);
    xlate(32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 3'd7, mk_pte(24'h000001, 0, 1, 1, 0), 2);
    // read-only read succeeds; write to it faults
    xlate(32'h0040_5ABC, 0, 32'h0000_1000, 3'd2, mk_pte(24'h123456, 0, 0, 1, 0), 1);
    xlate(32'h0040_5ABC, 1, 32'h0000_1000, 3'd2, mk_pte(24'h123456, 0, 0, 1, 0), 3);
    xlate(32'h0000_0000, 1, 32'h0, 3'd0, mk_pte(24'hFFFFFF, 1, 1, 1, 1), 0);  // R10 after fault
    xlate(32'h0123_4FFF, 0, 32'h0, 3'd1, mk_pte(24'h777777, 0, 1, 0, 0), 0);  // R3 read invalid
    ack_irq();
    xlate(32'h0123_4FFF, 1, 32'h0, 3'd1, mk_pte(24'h777777, 0, 1, 0, 0), 1);  // R3 write invalid
    for (int n = 0; n < 200; n++) begin
      xlate($urandom, 1'($urandom), $urandom, 3'($urandom),
            mk_pte(24'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom)),
            $urandom % 4);
      if ($urandom % 8 == 0) ack_irq();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule